// File: doc/BRIEF.md
# Parallel Prefix OR Tree

This block takes a vector of single-bit lanes and produces, for every lane position k, the OR of lane 0 through lane k. All prefix results come out together. The tree is built only from two-input combining nodes. There are log2(N) levels of nodes. The level with index L pairs each lane whose bit L is set with the last lane of the lower half of its block of width 2^(L+1). That lower-half result fans out across the upper half. A simple chain has a depth of N-1 nodes. With the default eight lanes this tree has a depth of three and uses twelve nodes.

The combining operator is chosen by a parameter. In OR mode the generate lanes are combined by OR and the propagate inputs play no part. In carry mode each lane carries a generate/propagate pair. The same tree then returns the group generate and group propagate of lanes 0..k, and a surrounding adder can use these directly as carries. The block has no state and no clock. The house convention of a named state machine has no place here: there are no states and no transitions, and the outputs are a pure function of the current inputs.

Top module: `prefix_or_tree`

## Requirements
- R1: Output lane 0 (`data_o[0]`) always equals `data_i[0]`, in both modes.
- R2: In OR mode (`OP = OP_OR`, encoding 0), `data_o[k]` equals the OR of `data_i[0]` through `data_i[k]` for every k and every input pattern.
- R3: In OR mode, the most significant output lane equals the OR of all input lanes.
- R4: In OR mode, `prop_i` has no effect on any output, and `prop_o` is all zeros.
- R5: In OR mode the outputs are monotonic. If `data_o[k]` is 1, then `data_o[k+1]` is also 1.
- R6: In carry mode (`OP = OP_CARRY`, encoding 1), lane k of `prop_o` equals the AND of `prop_i[0]` through `prop_i[k]`. Lane k of `data_o` equals the group generate G of lanes 0..k. G is built by starting from lane 0 and, for each higher lane j in turn, setting G = g[j] | (p[j] & G). Here lane index 0 is the least significant lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | N | Per-lane OR input (the generate bit in carry mode) |
| prop_i | input | N | Per-lane propagate bit, used in carry mode only |
| data_o | output | N | Prefix result for lanes 0..k (group generate in carry mode) |
| prop_o | output | N | Group propagate for lanes 0..k in carry mode, zero in OR mode |

## Verification
The OR-mode instance is driven with all 256 eight-bit patterns. This covers the all-zero word, a single set bit at each position (which shows whether each level's fan-out reaches the full upper half) and the all-ones word. Each pattern is paired with several `prop_i` values, which shows whether the propagate path leaks into OR mode. The carry-mode instance sees all 256 generate patterns against four propagate patterns: all ones, all zeros, alternating and a pattern-derived word. Together these separate a node that swaps its high and low operands from one that drops the propagate term.

// File: rtl/prefix_tree_pkg.sv
package prefix_tree_pkg;

    typedef enum logic [0:0] {
        OP_OR    = 1'b0,
        OP_CARRY = 1'b1
    } prefix_op_e;

    typedef struct packed {
        logic gen;
        logic prop;
    } lane_t;

    // hi is the more significant group, lo the less significant one
    function automatic lane_t merge_lanes(prefix_op_e op, lane_t hi, lane_t lo);
        lane_t r;
        unique case (op)
            OP_OR: begin
                r.gen  = hi.gen | lo.gen;
                r.prop = 1'b0;
            end
            OP_CARRY: begin
                r.gen  = hi.gen | (hi.prop & lo.gen);
                r.prop = hi.prop & lo.prop;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/prefix_cell.sv
module prefix_cell
    import prefix_tree_pkg::*;
#(
    parameter prefix_op_e OP = OP_OR
) (
    input  lane_t hi_i,
    input  lane_t lo_i,
    output lane_t res_o
);

    assign res_o = merge_lanes(OP, hi_i, lo_i);

endmodule

// File: rtl/prefix_level.sv
module prefix_level
    import prefix_tree_pkg::*;
#(
    parameter int         N   = 8,
    parameter int         LVL = 0,
    parameter prefix_op_e OP  = OP_OR
) (
    input  lane_t [N-1:0] lanes_i,
    output lane_t [N-1:0] lanes_o
);

    localparam int DIST = 1 << LVL;

    for (genvar i = 0; i < N; i++) begin : g_lane
        localparam int BLK = i / DIST;
        if ((BLK % 2) == 1) begin : g_node
            localparam int SRC = BLK * DIST - 1;
            prefix_cell #(.OP(OP)) cell_i (
                .hi_i (lanes_i[i]),
                .lo_i (lanes_i[SRC]),
                .res_o(lanes_o[i])
            );
        end else begin : g_pass
            assign lanes_o[i] = lanes_i[i];
        end
    end

endmodule

// File: rtl/prefix_or_tree.sv
module prefix_or_tree
    import prefix_tree_pkg::*;
#(
    parameter int         N  = 8,
    parameter prefix_op_e OP = OP_OR
) (
    input  logic [N-1:0] data_i,
    input  logic [N-1:0] prop_i,
    output logic [N-1:0] data_o,
    output logic [N-1:0] prop_o
);

    localparam int LEVELS = (N > 1) ? $clog2(N) : 1;

    lane_t [N-1:0] stage [0:LEVELS];

    for (genvar i = 0; i < N; i++) begin : g_in
        assign stage[0][i].gen  = data_i[i];
        assign stage[0][i].prop = (OP == OP_CARRY) ? prop_i[i] : 1'b0;
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        prefix_level #(.N(N), .LVL(l), .OP(OP)) level_i (
            .lanes_i(stage[l]),
            .lanes_o(stage[l+1])
        );
    end

    for (genvar i = 0; i < N; i++) begin : g_out
        assign data_o[i] = stage[LEVELS][i].gen;
        assign prop_o[i] = stage[LEVELS][i].prop;
    end

endmodule

// File: rtl/prefix_or_tree_chk.sv
module prefix_or_tree_chk
    import prefix_tree_pkg::*;
#(
    parameter int         N  = 8,
    parameter prefix_op_e OP = OP_OR
) (
    input logic [N-1:0] data_i,
    input logic [N-1:0] prop_i,
    input logic [N-1:0] data_o,
    input logic [N-1:0] prop_o
);

    always_comb begin
        assert_lane0_R1: assert (data_o[0] == data_i[0]);
        if (OP == OP_OR) begin
            assert_top_all_R3: assert (data_o[N-1] == (|data_i));
            assert_prop_zero_R4: assert (prop_o == '0);
            for (int k = 0; k + 1 < N; k++) begin
                assert_monotonic_R5: assert (!data_o[k] || data_o[k+1]);
                assert_step_R2: assert (data_o[k+1] == (data_o[k] | data_i[k+1]));
            end
        end else begin
            assert_prop0_R6: assert (prop_o[0] == prop_i[0]);
            for (int k = 0; k + 1 < N; k++) begin
                assert_prop_drop_R6: assert (!prop_o[k+1] || prop_o[k]);
            end
        end
    end

endmodule

bind prefix_or_tree prefix_or_tree_chk #(.N(N), .OP(OP)) chk_i (.*);

// File: tb/prefix_or_tree_tb_top.sv
module prefix_or_tree_tb_top;
    import prefix_tree_pkg::*;

    localparam int N = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [N-1:0] or_d, or_p, or_do, or_po;
    logic [N-1:0] cy_d, cy_p, cy_do, cy_po;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    prefix_or_tree #(.N(N), .OP(OP_OR)) dut_i (
        .data_i(or_d), .prop_i(or_p), .data_o(or_do), .prop_o(or_po)
    );

    prefix_or_tree #(.N(N), .OP(OP_CARRY)) dut_c (
        .data_i(cy_d), .prop_i(cy_p), .data_o(cy_do), .prop_o(cy_po)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] ref_or(input logic [N-1:0] x);
        logic [N-1:0] r;
        logic acc = 1'b0;
        for (int k = 0; k < N; k++) begin
            acc  = acc | x[k];
            r[k] = acc;
        end
        return r;
    endfunction

    function automatic logic [2*N-1:0] ref_carry(input logic [N-1:0] g, input logic [N-1:0] p);
        logic [N-1:0] rg, rp;
        logic ag = 1'b0;
        logic ap = 1'b1;
        for (int k = 0; k < N; k++) begin
            ag    = g[k] | (p[k] & ag);
            ap    = ap & p[k];
            rg[k] = ag;
            rp[k] = ap;
        end
        return {rg, rp};
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [2*N-1:0] cref;
        logic [N-1:0]   pvar [4];
        or_d = '0; or_p = '0; cy_d = '0; cy_p = '0;
        @(negedge clk);
        // zero-input state
        check("R1 zero", or_do, '0);
        check("R4 zero", or_po, '0);
        for (int v = 0; v < 256; v++) begin
            pvar[0] = 8'hFF;
            pvar[1] = 8'h00;
            pvar[2] = 8'hAA;
            pvar[3] = 8'(v * 37) ^ 8'h5C;
            for (int j = 0; j < 4; j++) begin
                @(posedge clk);
                #1;
                or_d = 8'(v);
                or_p = pvar[j];
                cy_d = 8'(v);
                cy_p = pvar[j];
                @(negedge clk);
                check("R2 prefix OR", or_do, ref_or(8'(v)));
                check("R1 lane0", {7'b0, or_do[0]}, {7'b0, or_d[0]});
                check("R3 total OR", {7'b0, or_do[N-1]}, {7'b0, |or_d});
                check("R4 prop ignored", or_po, '0);
                cref = ref_carry(cy_d, cy_p);
                check("R6 group generate", cy_do, cref[2*N-1:N]);
                check("R6 group propagate", cy_po, cref[N-1:0]);
                check("R1 carry lane0", {7'b0, cy_do[0]}, {7'b0, cy_d[0]});
            end
        end
        // single-bit patterns: fan-out of each level and R5 monotonicity
        for (int b = 0; b < N; b++) begin
            @(posedge clk);
            #1;
            or_d = 8'(1 << b);
            @(negedge clk);
            check("R5 single bit", or_do, ~8'((1 << b) - 1));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule